// File: doc/BRIEF.md
# Ternary Logic Gate Unit

This unit is a purely combinational evaluator for three-valued logic. Each digit (trit) travels on two wires, and the unit accepts two trit operands together with a 4-bit operator select. It returns a single trit result and, alongside it, a three-line unary decode of the first operand. Downstream logic can use the decode to steer ternary multiplexers.

The operator set has three families:

- **Inverters** on the first operand: standard, positive and negative.
- **Min and max** (the ternary AND and OR) on both operands, together with their standard complements.
- **Modulo-3 sum** of the two operands, with the carry dropped, together with its standard complement.

An operand that carries the unused two-bit code is treated as a fault, and the fault is made visible on every output.

Top module: `tri_gate_unit`

## Requirements
- R1: Trits are coded 2'b00 = 0, 2'b01 = 1 (intermediate) and 2'b10 = 2. If either operand carries 2'b11, the result and all three decode outputs are 2'b11.
- R2: For a legal first operand, the decode output whose index equals the operand value (dec_lo_o for 0, dec_mid_o for 1, dec_hi_o for 2) reads 2'b10, and the other two read 2'b00.
- R3: Select 4'd0 returns the standard inverse of A, which is 2 minus A.
- R4: Select 4'd1 returns the positive inverse of A: 0 when A is 2, and 2 otherwise.
- R5: Select 4'd2 returns the negative inverse of A: 2 when A is 0, and 0 otherwise.
- R6: Select 4'd3 returns min(A,B) and select 4'd4 returns max(A,B).
- R7: Select 4'd5 returns 2 minus min(A,B) and select 4'd6 returns 2 minus max(A,B).
- R8: Select 4'd7 returns (A+B) mod 3.
- R9: Select 4'd8 returns 2 minus ((A+B) mod 3).
- R10: With legal operands, select codes 4'd9 through 4'd15 return 2'b00.
- R11: With a legal B, the value of B has no effect on the result for selects 4'd0 to 4'd2, nor on any decode output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 2 | First trit operand |
| opb_i | input | 2 | Second trit operand |
| op_sel_i | input | 4 | Operator select |
| res_o | output | 2 | Trit result |
| dec_lo_o | output | 2 | Decode line, high when A is 0 |
| dec_mid_o | output | 2 | Decode line, high when A is 1 |
| dec_hi_o | output | 2 | Decode line, high when A is 2 |

## Verification
The bench builds the unit with its package defaults: a two-bit trit and a four-bit select. At those widths the whole input space is only 256 points, so the bench sweeps every point. The sweep therefore covers the illegal code in each operand position, every unused select, and every pairing of B with each inverter. Expected results are derived in the bench from integer min, max and modulo arithmetic.

// File: rtl/tern_pkg.sv
package tern_pkg;
    localparam int TRIT_W = 2;
    localparam int SEL_W  = 4;
    localparam int LEVELS = 3;

    typedef logic [TRIT_W-1:0] trit_t;

    localparam trit_t T_LO  = 2'b00;
    localparam trit_t T_MID = 2'b01;
    localparam trit_t T_HI  = 2'b10;
    localparam trit_t T_BAD = 2'b11;

    typedef enum logic [SEL_W-1:0] {
        OP_STD_INV = 4'd0,
        OP_POS_INV = 4'd1,
        OP_NEG_INV = 4'd2,
        OP_MIN     = 4'd3,
        OP_MAX     = 4'd4,
        OP_NMIN    = 4'd5,
        OP_NMAX    = 4'd6,
        OP_SUM3    = 4'd7,
        OP_NSUM3   = 4'd8
    } op_e;

    typedef struct packed {
        trit_t std_inv;
        trit_t pos_inv;
        trit_t neg_inv;
    } unary_t;

    typedef struct packed {
        trit_t lo;
        trit_t hi;
        trit_t sum3;
    } dyadic_t;

    function automatic logic trit_ok(trit_t t);
        return t != T_BAD;
    endfunction

    function automatic trit_t std_inv(trit_t t);
        return T_HI - t;
    endfunction

    function automatic trit_t add_mod3(trit_t x, trit_t y);
        logic [TRIT_W:0] s;
        s = {1'b0, x} + {1'b0, y};
        if (s >= 3'(LEVELS)) s = s - 3'(LEVELS);
        return s[TRIT_W-1:0];
    endfunction
endpackage

// File: rtl/tern_decoder.sv
module tern_decoder
    import tern_pkg::*;
(
    input  trit_t in_t,
    output trit_t lines [LEVELS]
);
    for (genvar k = 0; k < LEVELS; k++) begin : g_line
        assign lines[k] = (in_t == trit_t'(k)) ? T_HI : T_LO;
    end
endmodule

// File: rtl/tern_unary.sv
module tern_unary
    import tern_pkg::*;
(
    input  trit_t  in_t,
    output unary_t inv
);
    always_comb begin
        inv.std_inv = std_inv(in_t);
        inv.pos_inv = (in_t == T_HI)  ? T_LO : T_HI;
        inv.neg_inv = (in_t == T_LO)  ? T_HI : T_LO;
    end
endmodule

// File: rtl/tern_dyadic.sv
module tern_dyadic
    import tern_pkg::*;
(
    input  trit_t   x,
    input  trit_t   y,
    output dyadic_t o
);
    always_comb begin
        o.lo   = (x < y) ? x : y;
        o.hi   = (x < y) ? y : x;
        o.sum3 = add_mod3(x, y);
    end
endmodule

// File: rtl/tri_gate_unit.sv
module tri_gate_unit
    import tern_pkg::*;
(
    input  logic [1:0] opa_i,
    input  logic [1:0] opb_i,
    input  logic [3:0] op_sel_i,
    output logic [1:0] res_o,
    output logic [1:0] dec_lo_o,
    output logic [1:0] dec_mid_o,
    output logic [1:0] dec_hi_o
);
    trit_t   lines [LEVELS];
    unary_t  un;
    dyadic_t dy;
    trit_t   pick;
    logic    fault;

    tern_decoder u_dec (.in_t(opa_i), .lines(lines));
    tern_unary   u_un  (.in_t(opa_i), .inv(un));
    tern_dyadic  u_dy  (.x(opa_i), .y(opb_i), .o(dy));

    assign fault = !(trit_ok(opa_i) && trit_ok(opb_i));

    always_comb begin
        unique case (op_sel_i)
            OP_STD_INV: pick = un.std_inv;
            OP_POS_INV: pick = un.pos_inv;
            OP_NEG_INV: pick = un.neg_inv;
            OP_MIN:     pick = dy.lo;
            OP_MAX:     pick = dy.hi;
            OP_NMIN:    pick = std_inv(dy.lo);
            OP_NMAX:    pick = std_inv(dy.hi);
            OP_SUM3:    pick = dy.sum3;
            OP_NSUM3:   pick = std_inv(dy.sum3);
            default:    pick = T_LO;
        endcase
    end

    assign res_o     = fault ? T_BAD : pick;
    assign dec_lo_o  = fault ? T_BAD : lines[0];
    assign dec_mid_o = fault ? T_BAD : lines[1];
    assign dec_hi_o  = fault ? T_BAD : lines[2];
endmodule

// File: rtl/tern_gate_chk.sv
module tern_gate_chk (
    input logic [1:0] opa_i,
    input logic [1:0] opb_i,
    input logic [3:0] op_sel_i,
    input logic [1:0] res_o,
    input logic [1:0] dec_lo_o,
    input logic [1:0] dec_mid_o,
    input logic [1:0] dec_hi_o
);
    logic legal;
    logic [1:0] hi_cnt;
    always_comb begin
        legal  = (opa_i != 2'b11) && (opb_i != 2'b11);
        hi_cnt = 2'((dec_lo_o == 2'b10)) + 2'((dec_mid_o == 2'b10)) + 2'((dec_hi_o == 2'b10));
        if (!legal)
            assert_fault_flag_R1: assert (res_o == 2'b11 && dec_lo_o == 2'b11 &&
                                          dec_mid_o == 2'b11 && dec_hi_o == 2'b11);
        if (legal)
            assert_result_legal_R1: assert (res_o != 2'b11);
        if (legal)
            assert_decode_single_R2: assert (hi_cnt == 2'd1 &&
                ((opa_i == 2'b00) ? dec_lo_o : (opa_i == 2'b01) ? dec_mid_o : dec_hi_o) == 2'b10);
        if (legal && op_sel_i == 4'd0)
            assert_std_inv_R3: assert (res_o + opa_i == 2'b10);
        if (legal && op_sel_i == 4'd3)
            assert_min_bound_R6: assert (res_o <= opa_i && res_o <= opb_i);
        if (legal && op_sel_i == 4'd4)
            assert_max_bound_R6: assert (res_o >= opa_i && res_o >= opb_i);
        if (legal && op_sel_i >= 4'd9)
            assert_unused_zero_R10: assert (res_o == 2'b00);
    end
endmodule

bind tri_gate_unit tern_gate_chk chk_i (.*);

// File: tb/tri_gate_unit_tb_top.sv
module tri_gate_unit_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [1:0] a, b, res, dlo, dmid, dhi;
    logic [3:0] sel;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    tri_gate_unit dut_i (
        .opa_i(a), .opb_i(b), .op_sel_i(sel), .res_o(res),
        .dec_lo_o(dlo), .dec_mid_o(dmid), .dec_hi_o(dhi)
    );

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d sel=%0d got=%0d exp=%0d", req, a, b, sel, got, exp);
        end
    endtask

    function automatic int expect_res(int x, int y, int s);
        int mn = (x < y) ? x : y;
        int mx = (x < y) ? y : x;
        case (s)
            0: return 2 - x;
            1: return (x == 2) ? 0 : 2;
            2: return (x == 0) ? 2 : 0;
            3: return mn;
            4: return mx;
            5: return 2 - mn;
            6: return 2 - mx;
            7: return (x + y) % 3;
            8: return 2 - ((x + y) % 3);
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int y, int s);
        if (s <= 2 && y != 0) return "R11";
        case (s)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3, 4: return "R6";
            5, 6: return "R7";
            7: return "R8";
            8: return "R9";
            default: return "R10";
        endcase
    endfunction

    initial begin
        a = 2'b00; b = 2'b00; sel = 4'd0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // startup state with zero inputs: R2 decode and R3 inverse
        check("R2", dlo, 2'b10);
        check("R3", res, 2'b10);
        for (int x = 0; x < 4; x++) begin
            for (int y = 0; y < 4; y++) begin
                for (int s = 0; s < 16; s++) begin
                    @(negedge clk);
                    a = 2'(x); b = 2'(y); sel = 4'(s);
                    #2;
                    if (x == 3 || y == 3) begin
                        check("R1", res, 2'b11);
                        check("R1", dlo, 2'b11);
                        check("R1", dmid, 2'b11);
                        check("R1", dhi, 2'b11);
                    end else begin
                        check(tag_of(y, s), res, 2'(expect_res(x, y, s)));
                        check(y != 0 ? "R11" : "R2", dlo,  (x == 0) ? 2'b10 : 2'b00);
                        check(y != 0 ? "R11" : "R2", dmid, (x == 1) ? 2'b10 : 2'b00);
                        check(y != 0 ? "R11" : "R2", dhi,  (x == 2) ? 2'b10 : 2'b00);
                    end
                end
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule